// File: doc/BRIEF.md
# Ready-Latency TLP Transmit Adapter

This block sits between an application that produces transaction-layer packets with an ordinary valid/ready handshake (a beat moves in any cycle where both are high) and a transmit sink whose ready output works with a fixed latency. When the sink shows ready in cycle n, it will take a beat in cycle n+3. The sink does not promise to take a beat in any other cycle. The adapter stores accepted beats in a small store. It follows the sink's ready history and presents a beat only in cycles the sink has granted. Data, header, prefix, start, end and error qualifiers pass through unchanged.

Each packet must go out without an idle cycle between its first and last beat, except in cycles the sink has not granted. To guarantee this, the adapter starts a packet only once the packet's last beat is already stored. After that, every granted cycle carries the next beat until the packet ends. Both the sink ready input and the outgoing valid are registered, and these registers use up part of the three-cycle budget. Header and prefix are kept only from the first beat of a packet. An error flag is kept only on a last beat, where it marks the packet as nullified.

Top module: `tlp_rl_tx_adapter`

## Requirements
- R1: dn_valid is high in cycle k only if dn_ready was high in cycle k-3. While dn_ready stays low, no beat leaves.
- R2: After a packet's first beat has left, every following granted cycle (dn_ready high three cycles earlier) carries a beat of that packet, until the beat with dn_eop has left.
- R3: Beats leave in the order they were accepted (up_valid and up_ready both high), with data, start and end flags unchanged, none lost and none repeated.
- R4: On a first beat (dn_sop high), dn_hdr and dn_pfx equal the values presented with that beat's up_sop. On any other valid beat, both are zero, whatever was on up_hdr and up_pfx.
- R5: up_ready is low exactly when the store holds DEPTH beats. With the sink never granting, DEPTH single-beat packets are accepted and then up_ready stays low.
- R6: A packet's first beat leaves no earlier than two cycles after its last beat was accepted.
- R7: With the sink granting every cycle, a single-beat packet accepted in cycle t leaves in cycle t+2.
- R8: During reset and in the cycle after it, dn_valid, dn_sop, dn_eop and dn_err are low and up_ready is high.
- R9: In every cycle where dn_valid is low, dn_sop, dn_eop and dn_err are low.
- R10: An up_err presented on a beat without up_eop is dropped. dn_err is only ever high together with dn_eop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| up_valid | input | 1 | Application beat valid |
| up_ready | output | 1 | Adapter can take a beat this cycle |
| up_data | input | DATA_W | Beat payload |
| up_hdr | input | HDR_W | Header, used on start beats only |
| up_pfx | input | PFX_W | Prefix, used on start beats only |
| up_sop | input | 1 | First beat of a packet |
| up_eop | input | 1 | Last beat of a packet |
| up_err | input | 1 | Nullify flag, used on last beats only |
| dn_ready | input | 1 | Sink ready, grants the cycle READY_LAT later |
| dn_valid | output | 1 | Beat presented to the sink |
| dn_data | output | DATA_W | Beat payload |
| dn_hdr | output | HDR_W | Header on start beats, zero otherwise |
| dn_pfx | output | PFX_W | Prefix on start beats, zero otherwise |
| dn_sop | output | 1 | First beat of a packet |
| dn_eop | output | 1 | Last beat of a packet |
| dn_err | output | 1 | Packet nullified, only with dn_eop |

## Verification
- A sink grant in cycle n takes effect on dn_valid in cycle n+3.
- An accepted beat reaches the outputs at the earliest two cycles after its acceptance cycle.
- A change in fill level shows on up_ready in the cycle after the edge that caused it.

The bench drives all inputs away from the rising edge and samples everything on the falling edge. It stamps each accepted beat and each outgoing beat with a cycle number, and keeps an eight-entry ring of the dn_ready values it drove. Grant and contiguity checks compare dn_valid in cycle k with the ring entry for k-3. Latency checks compare the stamps against the exact offsets stated above.

// File: rtl/tlp_rl_pkg.sv
package tlp_rl_pkg;

   typedef enum logic {
      TX_IDLE = 1'b0,
      TX_BODY = 1'b1
   } tx_state_e;

   function automatic int unsigned idx_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/tlp_rl_ready_track.sv
// Delays the sink ready so that slot_ok is high in the cycle where a pop
// lands on the output register exactly READY_LAT cycles after the grant.
module tlp_rl_ready_track #(
   parameter int unsigned READY_LAT = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic sink_ready,
   output logic slot_ok
);
   localparam int unsigned STAGES = READY_LAT - 1;

   generate
      if (STAGES == 1) begin : g_one
         logic q;
         always_ff @(posedge clk) begin
            if (rst) q <= 1'b0;
            else     q <= sink_ready;
         end
         assign slot_ok = q;
      end else begin : g_chain
         logic [STAGES-1:0] q;
         always_ff @(posedge clk) begin
            if (rst) q <= '0;
            else     q <= {q[STAGES-2:0], sink_ready};
         end
         assign slot_ok = q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/tlp_rl_beat_store.sv
// Circular beat store that also counts the complete packets it holds.
module tlp_rl_beat_store #(
   parameter int unsigned BEAT_W = 8,
   parameter int unsigned DEPTH  = 4
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         push,
   input  logic                         push_last,
   input  logic [BEAT_W-1:0]            push_beat,
   input  logic                         pop,
   output logic [BEAT_W-1:0]            head_beat,
   output logic                         head_last,
   output logic                         full,
   output logic                         empty,
   output logic [$clog2(DEPTH+1)-1:0]   whole_pkts
);
   localparam int unsigned AW = tlp_rl_pkg::idx_bits(DEPTH);
   localparam int unsigned CW = $clog2(DEPTH + 1);

   logic [BEAT_W-1:0] mem [DEPTH];
   logic [DEPTH-1:0]  last_f;
   logic [AW-1:0]     wr_ptr;
   logic [AW-1:0]     rd_ptr;
   logic [CW-1:0]     fill;
   logic              do_push;
   logic              do_pop;

   assign do_push   = push & ~full;
   assign do_pop    = pop & ~empty;
   assign full      = (fill == CW'(DEPTH));
   assign empty     = (fill == '0);
   assign head_beat = mem[rd_ptr];
   assign head_last = last_f[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= push_beat;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr     <= '0;
         rd_ptr     <= '0;
         fill       <= '0;
         last_f     <= '0;
         whole_pkts <= '0;
      end else begin
         if (do_push) begin
            wr_ptr         <= wr_ptr + AW'(1);
            last_f[wr_ptr] <= push_last;
         end
         if (do_pop) rd_ptr <= rd_ptr + AW'(1);
         fill       <= fill + CW'(do_push) - CW'(do_pop);
         whole_pkts <= whole_pkts + CW'(do_push & push_last)
                                  - CW'(do_pop & head_last);
      end
   end

endmodule

// File: rtl/tlp_rl_tx_adapter.sv
module tlp_rl_tx_adapter
   import tlp_rl_pkg::*;
#(
   parameter int unsigned DATA_W       = 256,
   parameter int unsigned HDR_W        = 128,
   parameter int unsigned PFX_W        = 32,
   parameter int unsigned DEPTH        = 4,
   parameter int unsigned READY_LAT    = 3,
   parameter bit          HOLD_PAYLOAD = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              up_valid,
   output logic              up_ready,
   input  logic [DATA_W-1:0] up_data,
   input  logic [HDR_W-1:0]  up_hdr,
   input  logic [PFX_W-1:0]  up_pfx,
   input  logic              up_sop,
   input  logic              up_eop,
   input  logic              up_err,
   input  logic              dn_ready,
   output logic              dn_valid,
   output logic [DATA_W-1:0] dn_data,
   output logic [HDR_W-1:0]  dn_hdr,
   output logic [PFX_W-1:0]  dn_pfx,
   output logic              dn_sop,
   output logic              dn_eop,
   output logic              dn_err
);
   localparam int unsigned HDR_LO = DATA_W;
   localparam int unsigned PFX_LO = HDR_LO + HDR_W;
   localparam int unsigned SOP_B  = PFX_LO + PFX_W;
   localparam int unsigned EOP_B  = SOP_B + 1;
   localparam int unsigned ERR_B  = SOP_B + 2;
   localparam int unsigned BEAT_W = ERR_B + 1;
   localparam int unsigned CW     = $clog2(DEPTH + 1);

   // elaboration-time parameter checks
   if (DEPTH < 4) begin : g_bad_depth
      $error("tlp_rl_tx_adapter: DEPTH must be at least 4");
   end
   if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_pow2
      $error("tlp_rl_tx_adapter: DEPTH must be a power of two");
   end
   if (READY_LAT < 2) begin : g_bad_lat
      $error("tlp_rl_tx_adapter: READY_LAT must be at least 2");
   end
   if (DATA_W == 0 || HDR_W == 0 || PFX_W == 0) begin : g_bad_width
      $error("tlp_rl_tx_adapter: field widths must be non-zero");
   end

   logic              st_full;
   logic              st_empty;
   logic [CW-1:0]     whole_pkts;
   logic [BEAT_W-1:0] wr_beat;
   logic [BEAT_W-1:0] head_beat;
   logic              head_last;
   logic              push;
   logic              pop;
   logic              slot_ok;
   logic              pkt_ready;
   tx_state_e         tx_state;

   // ---------------- upstream side ----------------
   assign up_ready = ~st_full;
   assign push     = up_valid & up_ready;

   always_comb begin
      wr_beat                    = '0;
      wr_beat[DATA_W-1:0]        = up_data;
      wr_beat[HDR_LO +: HDR_W]   = up_sop ? up_hdr : '0;
      wr_beat[PFX_LO +: PFX_W]   = up_sop ? up_pfx : '0;
      wr_beat[SOP_B]             = up_sop;
      wr_beat[EOP_B]             = up_eop;
      wr_beat[ERR_B]             = up_err & up_eop;
   end

   tlp_rl_beat_store #(
      .BEAT_W (BEAT_W),
      .DEPTH  (DEPTH)
   ) u_store (
      .clk        (clk),
      .rst        (rst),
      .push       (push),
      .push_last  (up_eop),
      .push_beat  (wr_beat),
      .pop        (pop),
      .head_beat  (head_beat),
      .head_last  (head_last),
      .full       (st_full),
      .empty      (st_empty),
      .whole_pkts (whole_pkts)
   );

   // ---------------- grant tracking ----------------
   tlp_rl_ready_track #(
      .READY_LAT (READY_LAT)
   ) u_track (
      .clk        (clk),
      .rst        (rst),
      .sink_ready (dn_ready),
      .slot_ok    (slot_ok)
   );

   // ---------------- release control ----------------
   // A packet may start only when it is complete in the store; once started,
   // all of its beats are present, so every granted slot carries one.
   assign pkt_ready = (tx_state == TX_BODY) || (whole_pkts != '0);
   assign pop       = slot_ok & ~st_empty & pkt_ready;

   always_ff @(posedge clk) begin
      if (rst)      tx_state <= TX_IDLE;
      else if (pop) tx_state <= head_last ? TX_IDLE : TX_BODY;
   end

   // ---------------- output register ----------------
   always_ff @(posedge clk) begin
      if (rst) begin
         dn_valid <= 1'b0;
         dn_sop   <= 1'b0;
         dn_eop   <= 1'b0;
         dn_err   <= 1'b0;
      end else begin
         dn_valid <= pop;
         dn_sop   <= pop & head_beat[SOP_B];
         dn_eop   <= pop & head_beat[EOP_B];
         dn_err   <= pop & head_beat[ERR_B];
      end
   end

   generate
      if (HOLD_PAYLOAD) begin : g_hold
         always_ff @(posedge clk) begin
            if (pop) begin
               dn_data <= head_beat[DATA_W-1:0];
               dn_hdr  <= head_beat[HDR_LO +: HDR_W];
               dn_pfx  <= head_beat[PFX_LO +: PFX_W];
            end
         end
      end else begin : g_clear
         always_ff @(posedge clk) begin
            if (rst || !pop) begin
               dn_data <= '0;
               dn_hdr  <= '0;
               dn_pfx  <= '0;
            end else begin
               dn_data <= head_beat[DATA_W-1:0];
               dn_hdr  <= head_beat[HDR_LO +: HDR_W];
               dn_pfx  <= head_beat[PFX_LO +: PFX_W];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/tlp_rl_tx_adapter_chk.sv
module tlp_rl_tx_adapter_chk #(
   parameter int unsigned HDR_W     = 128,
   parameter int unsigned PFX_W     = 32,
   parameter int unsigned DEPTH     = 4,
   parameter int unsigned READY_LAT = 3
) (
   input logic             clk,
   input logic             rst,
   input logic             up_valid,
   input logic             up_ready,
   input logic             dn_ready,
   input logic             dn_valid,
   input logic [HDR_W-1:0] dn_hdr,
   input logic [PFX_W-1:0] dn_pfx,
   input logic             dn_sop,
   input logic             dn_eop,
   input logic             dn_err
);
   localparam int unsigned OW = $clog2(DEPTH + 2) + 1;

   logic [READY_LAT-1:0] grant_sh;
   logic                 in_pkt;
   logic [OW-1:0]        occ;

   always_ff @(posedge clk) begin
      if (rst) begin
         grant_sh <= '0;
         in_pkt   <= 1'b0;
         occ      <= '0;
      end else begin
         grant_sh <= {grant_sh[READY_LAT-2:0], dn_ready};
         if (dn_valid) in_pkt <= (dn_sop & ~dn_eop) | (in_pkt & ~dn_eop);
         occ <= occ + OW'(up_valid & up_ready) - OW'(dn_valid);
      end
   end

   // R1: a beat only in a granted cycle
   assert_grant_only_R1: assert property (@(posedge clk) disable iff (rst)
      dn_valid |-> grant_sh[READY_LAT-1]);

   // R2: no idle granted cycle inside a packet
   assert_contiguous_R2: assert property (@(posedge clk) disable iff (rst)
      (in_pkt && grant_sh[READY_LAT-1]) |-> dn_valid);

   // R4: header and prefix zero on non-start beats
   assert_hdr_masked_R4: assert property (@(posedge clk) disable iff (rst)
      (dn_valid && !dn_sop) |-> (dn_hdr == '0 && dn_pfx == '0));

   // R5: upstream ready follows the beats held (output register excluded)
   assert_ready_fill_R5: assert property (@(posedge clk) disable iff (rst)
      up_ready == ((occ - OW'(dn_valid)) < OW'(DEPTH)));

   // R8: outputs quiet after reset
   assert_reset_state_R8: assert property (@(posedge clk)
      rst |=> (!dn_valid && !dn_sop && !dn_eop && !dn_err && up_ready));

   // R9: qualifiers low when not valid
   assert_quiet_flags_R9: assert property (@(posedge clk) disable iff (rst)
      !dn_valid |-> !(dn_sop || dn_eop || dn_err));

   // R10: error only with end of packet
   assert_err_with_eop_R10: assert property (@(posedge clk) disable iff (rst)
      dn_err |-> dn_eop);

endmodule

bind tlp_rl_tx_adapter tlp_rl_tx_adapter_chk #(
   .HDR_W     (HDR_W),
   .PFX_W     (PFX_W),
   .DEPTH     (DEPTH),
   .READY_LAT (READY_LAT)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .up_valid (up_valid),
   .up_ready (up_ready),
   .dn_ready (dn_ready),
   .dn_valid (dn_valid),
   .dn_hdr   (dn_hdr),
   .dn_pfx   (dn_pfx),
   .dn_sop   (dn_sop),
   .dn_eop   (dn_eop),
   .dn_err   (dn_err)
);

// File: tb/sim_tlp_rl_tx_adapter.sv
module sim_tlp_rl_tx_adapter;
   localparam int DW = 32;
   localparam int HW = 16;
   localparam int PW = 8;
   localparam int DEPTH = 4;
   localparam int RL = 3;
   localparam int EW = 3 + DW + HW + PW;
   typedef logic [EW-1:0] ent_t;

   // {sop, eop, err, data, hdr, pfx}
   localparam ent_t TBL [12] = '{
      {1'b1, 1'b1, 1'b0, 32'h1000_0001, 16'hA001, 8'h11},
      {1'b1, 1'b0, 1'b0, 32'h2000_0001, 16'hB002, 8'h22},
      {1'b0, 1'b0, 1'b1, 32'h2000_0002, 16'hDEAD, 8'hEE},
      {1'b0, 1'b1, 1'b1, 32'h2000_0003, 16'hBEEF, 8'h77},
      {1'b1, 1'b0, 1'b0, 32'h3000_0001, 16'hC003, 8'h33},
      {1'b0, 1'b1, 1'b0, 32'h3000_0002, 16'h1234, 8'h44},
      {1'b1, 1'b0, 1'b0, 32'h4000_0001, 16'hD004, 8'h55},
      {1'b0, 1'b0, 1'b0, 32'h4000_0002, 16'h5555, 8'h66},
      {1'b0, 1'b0, 1'b0, 32'h4000_0003, 16'h6666, 8'h77},
      {1'b0, 1'b1, 1'b0, 32'h4000_0004, 16'h7777, 8'h88},
      {1'b1, 1'b1, 1'b1, 32'h5000_0001, 16'hE005, 8'h99},
      {1'b1, 1'b1, 1'b0, 32'h6000_0001, 16'hF006, 8'hAA}
   };

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          up_valid = 1'b0;
   logic          up_ready;
   logic [DW-1:0] up_data = '0;
   logic [HW-1:0] up_hdr = '0;
   logic [PW-1:0] up_pfx = '0;
   logic          up_sop = 1'b0;
   logic          up_eop = 1'b0;
   logic          up_err = 1'b0;
   logic          dn_ready = 1'b0;
   logic          dn_valid;
   logic [DW-1:0] dn_data;
   logic [HW-1:0] dn_hdr;
   logic [PW-1:0] dn_pfx;
   logic          dn_sop;
   logic          dn_eop;
   logic          dn_err;

   int   checks = 0;
   int   failures = 0;
   int   cyc = 0;
   int   wd = 0;
   int   mode = 2;       // 0 always grant, 1 bursty, 2 never
   bit   done = 1'b0;
   ent_t exp_b [128];
   int   acccyc [128];
   int   outcyc [128];
   int   nexp = 0;
   int   nout = 0;
   bit   rh [8];
   bit   mpkt = 1'b0;
   bit   okslot;
   ent_t me;

   tlp_rl_tx_adapter #(
      .DATA_W(DW), .HDR_W(HW), .PFX_W(PW), .DEPTH(DEPTH), .READY_LAT(RL)
   ) u0 (
      .clk(clk), .rst(rst),
      .up_valid(up_valid), .up_ready(up_ready), .up_data(up_data),
      .up_hdr(up_hdr), .up_pfx(up_pfx), .up_sop(up_sop), .up_eop(up_eop),
      .up_err(up_err), .dn_ready(dn_ready), .dn_valid(dn_valid),
      .dn_data(dn_data), .dn_hdr(dn_hdr), .dn_pfx(dn_pfx), .dn_sop(dn_sop),
      .dn_eop(dn_eop), .dn_err(dn_err)
   );

   always #4 clk = ~clk;   // 125 MHz

   always @(posedge clk) begin
      if (rst) cyc <= 0;
      else     cyc <= cyc + 1;
   end

   task automatic chk(input bit ok, input string req,
                      input logic [63:0] got, input logic [63:0] expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s got=%0h exp=%0h", req, got, expv);
      end
   endtask

   // sink ready driver, away from the edge
   always begin
      @(posedge clk);
      #2;
      case (mode)
         0:       dn_ready = 1'b1;
         1:       dn_ready = ((cyc % 7) < 5);
         default: dn_ready = 1'b0;
      endcase
   end

   // output monitor
   always @(negedge clk) begin
      if (rst) begin
         for (int i = 0; i < 8; i++) rh[i] = 1'b0;
         mpkt = 1'b0;
      end else begin
         rh[cyc[2:0]] = dn_ready;
         okslot = (cyc >= 3) ? rh[3'(cyc - 3)] : 1'b0;
         if (dn_valid) begin
            chk(okslot, "R1 beat without grant", 1, 0);
            if (nout >= nexp) begin
               chk(0, "R3 extra beat", nout, nexp);
            end else begin
               me = exp_b[nout];
               chk({dn_sop, dn_eop, dn_data} == {me[58], me[57], me[55:24]},
                   "R3 beat order/content", {dn_sop, dn_eop, dn_data},
                   {me[58], me[57], me[55:24]});
               chk({dn_hdr, dn_pfx} == me[23:0], "R4 header/prefix",
                   {dn_hdr, dn_pfx}, me[23:0]);
               chk(dn_err == me[56], "R10 error flag", dn_err, me[56]);
               outcyc[nout] = cyc;
               nout++;
            end
            mpkt = (dn_sop & ~dn_eop) | (mpkt & ~dn_eop);
         end else begin
            chk(!(dn_sop | dn_eop | dn_err), "R9 flags while idle",
                {dn_sop, dn_eop, dn_err}, 0);
            if (mpkt) chk(!okslot, "R2 idle granted cycle in packet", 0, 1);
         end
      end
   end

   always @(posedge clk) begin
      wd++;
      if (wd > 20000 && !done) begin
         failures++;
         $display("FAIL R3 watchdog got=%0d exp<20000", wd);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic record(input ent_t e);
      exp_b[nexp]  = {e[58], e[57], e[56] & e[57], e[55:24],
                      e[58] ? e[23:8] : 16'h0, e[58] ? e[7:0] : 8'h0};
      acccyc[nexp] = cyc;
      nexp++;
   endtask

   task automatic send(input ent_t e, input int gap);
      up_valid = 1'b1;
      {up_sop, up_eop, up_err, up_data, up_hdr, up_pfx} = e;
      while (!up_ready) @(negedge clk);
      record(e);
      @(negedge clk);
      up_valid = 1'b0;
      repeat (gap) @(negedge clk);
   endtask

   task automatic drain(input string req);
      int n = 0;
      while (nout != nexp && n < 300) begin
         @(negedge clk);
         n++;
      end
      chk(nout == nexp, req, nout, nexp);
   endtask

   initial begin
      int base;
      int acc;
      int first;
      int c0;
      ent_t e;

      // reset state
      repeat (4) @(negedge clk);
      chk(!dn_valid && !dn_sop && !dn_eop && !dn_err, "R8 outputs in reset",
          {dn_valid, dn_sop, dn_eop, dn_err}, 0);
      rst = 1'b0;
      @(negedge clk);
      chk(up_ready && !dn_valid, "R8 after reset", {up_ready, dn_valid}, 2'b10);

      // table walk: pass 0 steady grant, pass 1 bursty grant with gaps
      for (int pass = 0; pass < 2; pass++) begin
         mode = pass;
         for (int i = 0; i < 12; i++) send(TBL[i], (pass == 1 && i % 3 == 0) ? 1 : 0);
         drain("R3 table drain");
      end

      // R5: sink never grants, store fills to DEPTH
      mode = 2;
      repeat (6) @(negedge clk);
      base = nout;
      acc = 0;
      up_valid = 1'b1;
      for (int k = 0; k < 10; k++) begin
         e = {1'b1, 1'b1, 1'b0, 32'h7000_0000 + acc, 16'h7700 + 16'(acc), 8'(acc)};
         {up_sop, up_eop, up_err, up_data, up_hdr, up_pfx} = e;
         if (up_ready) begin
            record(e);
            acc++;
         end
         @(negedge clk);
      end
      up_valid = 1'b0;
      chk(acc == DEPTH, "R5 beats accepted when full", acc, DEPTH);
      chk(!up_ready, "R5 up_ready low when full", up_ready, 0);
      chk(nout == base, "R1 no beat while never granted", nout, base);
      c0 = cyc;
      mode = 0;
      @(negedge clk);
      chk(outcyc[base] == c0 + 4 || nout == base, "R1 first grant timing",
          outcyc[base], c0 + 4);
      drain("R5 drain after fill");
      chk(outcyc[base] == c0 + 4, "R1 grant to first beat", outcyc[base], c0 + 4);

      // R7: single-beat latency with steady grant
      repeat (5) @(negedge clk);
      send({1'b1, 1'b1, 1'b0, 32'h8000_0001, 16'h8001, 8'h81}, 0);
      drain("R7 drain");
      chk(outcyc[nexp-1] == acccyc[nexp-1] + 2, "R7 latency",
          outcyc[nexp-1], acccyc[nexp-1] + 2);

      // R6: slow upstream packet is held until its last beat is stored
      repeat (5) @(negedge clk);
      first = nexp;
      send({1'b1, 1'b0, 1'b0, 32'h9000_0001, 16'h9001, 8'h91}, 4);
      send({1'b0, 1'b0, 1'b0, 32'h9000_0002, 16'h9999, 8'h92}, 4);
      send({1'b0, 1'b1, 1'b0, 32'h9000_0003, 16'h9998, 8'h93}, 0);
      drain("R6 drain");
      chk(outcyc[first] == acccyc[first+2] + 2, "R6 start after last stored",
          outcyc[first], acccyc[first+2] + 2);
      chk(outcyc[first+2] == outcyc[first] + 2, "R2 beats back to back",
          outcyc[first+2], outcyc[first] + 2);

      repeat (5) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule